// File: doc/BRIEF.md
# Multi-Lane Receive Framing Rule Checker

This block watches the receive side of a 4-, 8- or 16-lane serial link. Its input is the decoded, de-skewed symbol stream: one byte per lane and a control flag per lane, presented together as one symbol time. Each symbol time is checked against the lane placement rules for packet start and end characters, filler characters, ordered sets and logical idle. The per-lane walk carries the "packet open" state from lane to lane and from one symbol time to the next.

Any breach raises a one-cycle receiver error pulse toward the data link layer and sets a sticky error bit that software clears. A breach also closes any open packet, cancels any ordered set in progress and drops that symbol time's payload. Data bytes inside an accepted packet are passed upward with a per-lane valid mask. Start, end and filler characters never carry a valid flag, so framing is stripped.

Symbol codes (control flag set): COM = 0xBC, STP = 0xFB, SDP = 0x5C, END = 0xFD, EDB = 0xFE, PAD = 0xF7. Logical idle is data byte 0x00.

Top module: `rxf_lane_checker`

## Requirements
- R1: During and right after reset, rx_err, rx_err_sticky and every pld_vld bit are 0.
- R2: A start character (STP 0xFB or SDP 0x5C, control) is legal only on a lane whose number is a multiple of 4 and only when no packet is open. On lane 0 it needs a closed packet at the start of the symbol time. On any higher lane it must directly follow an END or EDB on the lane below. On a x4 link this leaves lane 0 only.
- R3: END (0xFD) or EDB (0xFE), control, is legal only on a lane numbered 4k+3 and only while a packet is open.
- R4: A start character while a packet is already open is an error.
- R5: PAD (0xF7, control) is legal only outside a packet, on the lane directly after an END/EDB or after another PAD in the same symbol time.
- R6: COM (0xBC, control) must be on all lanes or on none. All-lane COM with no packet open begins an ordered set of OS_LEN symbol times. In the OS_LEN-1 symbol times after it, every lane must carry the same symbol as lane 0, and no payload is passed. All-lane COM with a packet open is an error.
- R7: Outside a packet, a data byte is legal only as logical idle. That means 0x00 on every lane, in a symbol time that begins with no packet open. Any other data outside a packet is an error.
- R8: Outside an ordered set body, a control symbol other than COM, STP, SDP, END, EDB or PAD is an error.
- R9: Data bytes of an open packet appear on pld_byte, with the matching pld_vld bit set, one cycle after their symbol time. Lanes carrying framing characters have pld_vld 0.
- R10: rx_err is high exactly in the cycle after a violating symbol time. That symbol time yields no payload, and the link returns to no packet open and no ordered set.
- R11: rx_err_sticky is set together with rx_err and holds until err_clr. When an error and err_clr fall in the same cycle, the set wins.
- R12: While sym_vld is low, the input symbols change no state, raise no error and produce no payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_vld | input | 1 | A symbol time is present on all lanes |
| sym_byte | input | LANES*8 | Symbol byte per lane, lane i at bits 8i+7:8i |
| sym_is_k | input | LANES | Control flag per lane |
| err_clr | input | 1 | Clears the sticky error bit |
| rx_err | output | 1 | One-cycle receiver error pulse |
| rx_err_sticky | output | 1 | Sticky receiver error |
| pld_byte | output | LANES*8 | Packet bytes passed upward, same lane layout |
| pld_vld | output | LANES | Valid mask for pld_byte |

## Verification
Every result of this block comes from one register stage. The error pulse, the sticky bit and the payload for a symbol time are all due in the cycle after that symbol time is sampled. The bench drives each symbol time at a falling edge, lets one rising edge pass, and reads rx_err, rx_err_sticky, pld_vld and pld_byte at the next falling edge. It does this both for legal streams and for each kind of violation. State that a stimulus must leave alone, such as the open packet across an invalid symbol time, is read back through the payload of the next valid symbol time.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [7:0] SYM_COM = 8'hBC;
    localparam logic [7:0] SYM_STP = 8'hFB;
    localparam logic [7:0] SYM_SDP = 8'h5C;
    localparam logic [7:0] SYM_END = 8'hFD;
    localparam logic [7:0] SYM_EDB = 8'hFE;
    localparam logic [7:0] SYM_PAD = 8'hF7;

    // Classification of one lane symbol; exactly one field is set.
    typedef struct packed {
        logic start;    // STP or SDP
        logic stop;     // END or EDB
        logic pad;
        logic com;
        logic other_k;  // any other control symbol
        logic idle;     // data 0x00
        logic data;     // any other data byte
    } lane_cls_t;

endpackage

// File: rtl/rxf_lane_class.sv
module rxf_lane_class
    import rxf_pkg::*;
(
    input  logic [7:0] sym,
    input  logic       is_k,
    output lane_cls_t  cls
);
    always_comb begin
        cls = '0;
        if (is_k) begin
            unique case (sym)
                SYM_STP, SYM_SDP: cls.start   = 1'b1;
                SYM_END, SYM_EDB: cls.stop    = 1'b1;
                SYM_PAD:          cls.pad     = 1'b1;
                SYM_COM:          cls.com     = 1'b1;
                default:          cls.other_k = 1'b1;
            endcase
        end else if (sym == 8'h00) begin
            cls.idle = 1'b1;
        end else begin
            cls.data = 1'b1;
        end
    end
endmodule

// File: rtl/rxf_frame_scan.sv
// Walks the lanes of one symbol time from lane 0 upward, carrying the
// packet-open state, and flags every lane that breaks a placement rule.
module rxf_frame_scan
    import rxf_pkg::*;
#(
    parameter int LANES = 8
) (
    input  lane_cls_t              cls [LANES],
    input  logic                   open_in,
    output logic [LANES-1:0]       lane_err,
    output logic [LANES-1:0]       pld_mask,
    output logic                   open_out
);
    logic open_v;
    logic prev_stop;
    logic prev_pad;
    logic all_idle;

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            all_idle = all_idle & cls[i].idle;
        end
    end

    always_comb begin
        open_v    = open_in;
        prev_stop = 1'b0;
        prev_pad  = 1'b0;
        lane_err  = '0;
        pld_mask  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (cls[i].start) begin
                // R2/R4: aligned lane, closed packet, lane 0 or after an end
                if (open_v || (i % 4) != 0 || (i != 0 && !prev_stop))
                    lane_err[i] = 1'b1;
                open_v = 1'b1;
            end else if (cls[i].stop) begin
                // R3: lane 4k+3 with an open packet
                if (!open_v || (i % 4) != 3)
                    lane_err[i] = 1'b1;
                open_v = 1'b0;
            end else if (cls[i].pad) begin
                // R5: only as trailing filler after an end
                if (open_v || !(prev_stop || prev_pad))
                    lane_err[i] = 1'b1;
            end else if (cls[i].com) begin
                // all-lane rule is judged by the ordered set checker
                lane_err[i] = 1'b0;
            end else if (cls[i].other_k) begin
                lane_err[i] = 1'b1;                 // R8
            end else if (open_v) begin
                pld_mask[i] = 1'b1;                 // R9
            end else if (!(cls[i].idle && all_idle && !open_in)) begin
                lane_err[i] = 1'b1;                 // R7
            end
            prev_stop = cls[i].stop;
            prev_pad  = cls[i].pad;
        end
        open_out = open_v;
    end
endmodule

// File: rtl/rxf_os_check.sv
// Judges COM lane coverage and the lane consistency of ordered set bodies.
module rxf_os_check #(
    parameter int LANES  = 8,
    parameter int OS_LEN = 4,
    localparam int CNT_W = $clog2(OS_LEN)
) (
    input  logic [LANES*8-1:0] sym_byte,
    input  logic [LANES-1:0]   sym_is_k,
    input  logic [LANES-1:0]   com_mask,
    input  logic               open_q,
    input  logic [CNT_W-1:0]   os_cnt_q,
    output logic               os_busy,
    output logic               os_err,
    output logic [CNT_W-1:0]   os_cnt_d
);
    logic mismatch;

    always_comb begin
        mismatch = 1'b0;
        for (int i = 1; i < LANES; i++) begin
            if (sym_byte[8*i +: 8] != sym_byte[7:0] || sym_is_k[i] != sym_is_k[0])
                mismatch = 1'b1;
        end
    end

    always_comb begin
        os_busy  = 1'b0;
        os_err   = 1'b0;
        os_cnt_d = '0;
        if (os_cnt_q != '0) begin
            os_busy  = 1'b1;
            os_err   = mismatch;
            os_cnt_d = os_cnt_q - 1'b1;
        end else if (|com_mask) begin
            os_busy = 1'b1;
            if (!(&com_mask) || open_q)
                os_err = 1'b1;
            else
                os_cnt_d = CNT_W'(OS_LEN - 1);
        end
    end
endmodule

// File: rtl/rxf_lane_checker.sv
module rxf_lane_checker
    import rxf_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int OS_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_vld,
    input  logic [LANES*8-1:0] sym_byte,
    input  logic [LANES-1:0]   sym_is_k,
    input  logic               err_clr,
    output logic               rx_err,
    output logic               rx_err_sticky,
    output logic [LANES*8-1:0] pld_byte,
    output logic [LANES-1:0]   pld_vld
);
    localparam int CNT_W = $clog2(OS_LEN);

    typedef struct packed {
        logic               open;
        logic [CNT_W-1:0]   os_cnt;
        logic               err;
        logic               sticky;
        logic [LANES*8-1:0] pld_byte;
        logic [LANES-1:0]   pld_vld;
    } state_t;

    state_t st_d, st_q;

    lane_cls_t          cls [LANES];
    logic [LANES-1:0]   com_mask;
    logic [LANES-1:0]   lane_err;
    logic [LANES-1:0]   pld_mask;
    logic               scan_open;
    logic               os_busy;
    logic               os_err;
    logic [CNT_W-1:0]   os_cnt_d;
    logic               sym_err;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rxf_lane_class u_class (
            .sym  (sym_byte[8*g +: 8]),
            .is_k (sym_is_k[g]),
            .cls  (cls[g])
        );
        assign com_mask[g] = cls[g].com;
    end

    rxf_frame_scan #(.LANES(LANES)) u_scan (
        .cls      (cls),
        .open_in  (st_q.open),
        .lane_err (lane_err),
        .pld_mask (pld_mask),
        .open_out (scan_open)
    );

    rxf_os_check #(.LANES(LANES), .OS_LEN(OS_LEN)) u_os (
        .sym_byte (sym_byte),
        .sym_is_k (sym_is_k),
        .com_mask (com_mask),
        .open_q   (st_q.open),
        .os_cnt_q (st_q.os_cnt),
        .os_busy  (os_busy),
        .os_err   (os_err),
        .os_cnt_d (os_cnt_d)
    );

    assign sym_err = os_err | (!os_busy & (|lane_err));

    always_comb begin
        st_d          = st_q;
        st_d.err      = 1'b0;
        st_d.pld_vld  = '0;
        st_d.pld_byte = sym_byte;
        if (sym_vld) begin
            if (sym_err) begin
                st_d.err    = 1'b1;
                st_d.open   = 1'b0;
                st_d.os_cnt = '0;
            end else begin
                st_d.os_cnt = os_cnt_d;
                if (!os_busy) begin
                    st_d.open    = scan_open;
                    st_d.pld_vld = pld_mask;
                end
            end
        end
        if (st_d.err)
            st_d.sticky = 1'b1;
        else if (err_clr)
            st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_err        = st_q.err;
    assign rx_err_sticky = st_q.sticky;
    assign pld_byte      = st_q.pld_byte;
    assign pld_vld       = st_q.pld_vld;

    // ---------------- assertions ----------------
    assert_sticky_with_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> rx_err_sticky);

    assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_err_sticky) && !$past(err_clr)) |-> rx_err_sticky);

    assert_drop_on_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> (pld_vld == '0));

    assert_invalid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> (!rx_err && pld_vld == '0));

    assert_os_body_no_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && st_q.os_cnt != '0) |=> (pld_vld == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_rule_chk
        if (g % 4 != 0) begin : g_start
            assert_start_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (sym_vld && st_q.os_cnt == '0 && cls[g].start) |=> rx_err);
        end
        if (g % 4 != 3) begin : g_stop
            assert_stop_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (sym_vld && st_q.os_cnt == '0 && cls[g].stop) |=> rx_err);
        end
    end
endmodule

// File: tb/rxf_lane_checker_bench.sv
module rxf_lane_checker_bench;
    localparam int LANES = 8;
    localparam logic [7:0] K_COM = 8'hBC, K_STP = 8'hFB, K_SDP = 8'h5C,
                           K_END = 8'hFD, K_EDB = 8'hFE, K_PAD = 8'hF7,
                           K_SKP = 8'h1C, K_ALT = 8'h1D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_vld = 1'b0;
    logic err_clr = 1'b0;
    logic [LANES*8-1:0] sym_byte;
    logic [LANES-1:0]   sym_is_k;
    logic rx_err, rx_err_sticky;
    logic [LANES*8-1:0] pld_byte;
    logic [LANES-1:0]   pld_vld;

    logic [7:0] b [LANES];
    logic       k [LANES];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            sym_byte[8*i +: 8] = b[i];
            sym_is_k[i]        = k[i];
        end
    end

    rxf_lane_checker #(.LANES(LANES), .OS_LEN(4)) u_rxf_lane_checker (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_byte(sym_byte),
        .sym_is_k(sym_is_k), .err_clr(err_clr), .rx_err(rx_err),
        .rx_err_sticky(rx_err_sticky), .pld_byte(pld_byte), .pld_vld(pld_vld)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] base, input logic inc);
        for (int i = 0; i < LANES; i++) begin
            b[i] = inc ? base + 8'(i) : base;
            k[i] = 1'b0;
        end
    endtask

    task automatic setk(input int lane, input logic [7:0] code);
        b[lane] = code;
        k[lane] = 1'b1;
    endtask

    task automatic all_k(input logic [7:0] code);
        for (int i = 0; i < LANES; i++) setk(i, code);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step_chk(input logic e, input logic [7:0] v, input string tag);
        sym_vld = 1'b1;
        cyc();
        chk(32'(rx_err), 32'(e), {tag, " rx_err"});
        chk(32'(pld_vld), 32'(v), {tag, " pld_vld"});
    endtask

    task automatic idle_ok(input string tag);
        fill(8'h00, 1'b0);
        step_chk(1'b0, 8'h00, tag);
    endtask

    task automatic open_pkt(input string tag);
        fill(8'h10, 1'b1);
        setk(0, K_STP);
        step_chk(1'b0, 8'hFE, tag);
    endtask

    task automatic t_reset();
        chk(32'(rx_err), 0, "R1 rx_err in reset");
        chk(32'(rx_err_sticky), 0, "R1 sticky in reset");
        rst_n = 1'b1;
        cyc();
        chk(32'(pld_vld), 0, "R1 pld_vld after reset");
        idle_ok("R7 all-lane idle");
    endtask

    task automatic t_packet();
        open_pkt("R2 start lane0 after idle");
        chk(32'(pld_byte[15:8]), 32'h11, "R9 lane1 byte");
        chk(32'(pld_byte[63:56]), 32'h17, "R9 lane7 byte");
        fill(8'h20, 1'b1);
        step_chk(1'b0, 8'hFF, "R9 full payload");
        chk(32'(pld_byte[7:0]), 32'h20, "R9 lane0 byte");
        fill(8'h30, 1'b1);
        setk(3, K_END);
        for (int i = 4; i < LANES; i++) setk(i, K_PAD);
        step_chk(1'b0, 8'h07, "R3 R5 end lane3 pad after");
        idle_ok("R7 idle after packet");
    endtask

    task automatic t_back_to_back();
        fill(8'h40, 1'b1);
        setk(0, K_SDP);
        step_chk(1'b0, 8'hFE, "R2 sdp lane0");
        fill(8'h50, 1'b1);
        setk(3, K_EDB);
        setk(4, K_STP);
        step_chk(1'b0, 8'hE7, "R2 start lane4 after edb");
        fill(8'h60, 1'b1);
        setk(3, K_END);
        for (int i = 4; i < LANES; i++) setk(i, K_PAD);
        step_chk(1'b0, 8'h07, "R3 second packet end");
        idle_ok("R7 idle after b2b");
    endtask

    task automatic t_bad_start();
        fill(8'h00, 1'b0);
        setk(2, K_STP);
        step_chk(1'b1, 8'h00, "R2 start lane2");
        chk(32'(rx_err_sticky), 1, "R11 sticky set");
        idle_ok("R10 pulse lasts one cycle");
        chk(32'(rx_err_sticky), 1, "R11 sticky held");
        err_clr = 1'b1;
        idle_ok("R11 clear cycle");
        err_clr = 1'b0;
        chk(32'(rx_err_sticky), 0, "R11 sticky cleared");
        fill(8'h00, 1'b0);
        setk(4, K_STP);
        step_chk(1'b1, 8'h00, "R2 start lane4 after idle");
        idle_ok("R10 recovered");
    endtask

    task automatic t_bad_end();
        open_pkt("R2 open for R3");
        fill(8'h70, 1'b1);
        setk(5, K_END);
        setk(6, K_PAD);
        setk(7, K_PAD);
        step_chk(1'b1, 8'h00, "R3 end on lane5");
        idle_ok("R10 packet closed by error");
        open_pkt("R2 open for R3 closed end");
        fill(8'h70, 1'b1);
        setk(3, K_END);
        for (int i = 4; i < 7; i++) setk(i, K_PAD);
        setk(7, K_END);
        step_chk(1'b1, 8'h00, "R3 end with no open packet");
        idle_ok("R10 idle after R3");
    endtask

    task automatic t_start_open();
        open_pkt("R2 open for R4");
        fill(8'h21, 1'b1);
        setk(0, K_STP);
        step_chk(1'b1, 8'h00, "R4 start while open");
        idle_ok("R10 idle after R4");
    endtask

    task automatic t_pad();
        fill(8'h31, 1'b1);
        setk(0, K_STP);
        for (int i = 4; i < LANES; i++) setk(i, K_PAD);
        step_chk(1'b1, 8'h00, "R5 pad inside packet");
        idle_ok("R10 idle after R5");
    endtask

    task automatic t_ordered_sets();
        all_k(K_COM);
        step_chk(1'b0, 8'h00, "R6 all-lane com");
        for (int n = 0; n < 3; n++) begin
            all_k(K_SKP);
            step_chk(1'b0, 8'h00, "R6 consistent body");
        end
        all_k(K_SKP);
        step_chk(1'b1, 8'h00, "R8 control after set ends");
        idle_ok("R7 idle after R8");
        all_k(K_COM);
        step_chk(1'b0, 8'h00, "R6 com again");
        all_k(K_SKP);
        setk(5, K_ALT);
        step_chk(1'b1, 8'h00, "R6 body lane mismatch");
        idle_ok("R10 idle after mismatch");
        fill(8'h00, 1'b0);
        for (int i = 0; i < 4; i++) setk(i, K_COM);
        step_chk(1'b1, 8'h00, "R6 partial com");
        open_pkt("R2 open for R6");
        all_k(K_COM);
        step_chk(1'b1, 8'h00, "R6 com while open");
        idle_ok("R10 idle after R6");
    endtask

    task automatic t_idle_rules();
        fill(8'h55, 1'b0);
        step_chk(1'b1, 8'h00, "R7 data outside packet");
        open_pkt("R2 open for R7");
        fill(8'h00, 1'b0);
        b[0] = 8'h91; b[1] = 8'h92; b[2] = 8'h93;
        setk(3, K_END);
        step_chk(1'b1, 8'h00, "R7 idle filler after end");
        idle_ok("R10 idle after R7");
    endtask

    task automatic t_invalid();
        fill(8'h00, 1'b0);
        setk(2, K_STP);
        sym_vld = 1'b0;
        cyc();
        chk(32'(rx_err), 0, "R12 no error when invalid");
        open_pkt("R2 open for R12");
        fill(8'hA0, 1'b1);
        sym_vld = 1'b0;
        cyc();
        chk(32'(pld_vld), 0, "R12 no payload when invalid");
        fill(8'hB0, 1'b1);
        step_chk(1'b0, 8'hFF, "R12 packet still open");
        chk(32'(pld_byte[31:24]), 32'hB3, "R9 lane3 byte");
        fill(8'hC0, 1'b1);
        setk(3, K_END);
        for (int i = 4; i < LANES; i++) setk(i, K_PAD);
        step_chk(1'b0, 8'h07, "R3 close after R12");
    endtask

    task automatic t_set_wins();
        err_clr = 1'b1;
        fill(8'h55, 1'b0);
        step_chk(1'b1, 8'h00, "R11 error with clear");
        chk(32'(rx_err_sticky), 1, "R11 set wins over clear");
        idle_ok("R11 clear alone");
        err_clr = 1'b0;
        chk(32'(rx_err_sticky), 0, "R11 cleared after");
    endtask

    initial begin
        fill(8'h00, 1'b0);
        repeat (3) cyc();
        t_reset();
        t_packet();
        t_back_to_back();
        t_bad_start();
        t_bad_end();
        t_start_open();
        t_pad();
        t_ordered_sets();
        t_idle_rules();
        t_invalid();
        t_set_wins();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule